// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a 32-bit memory-mapped host reach an 8-bit register space that sits behind a slow inner port. The host does not address inner registers directly. It first writes a control word with an inner address, a direction and byte enables. Data then moves through a 32-bit data window. Each inner access is a two-step transaction. A write is launched by writing the data window while the stored direction is "write". A read is launched by writing a control word whose direction is "read". A busy bit in the control word stays high while the inner access is in flight, and the host polls it until it drops.

The inner register space is modelled as a byte memory with a fixed, parameterised access latency. The bridge also collects two interrupt sources into a small flag register that the host clears by writing ones. A matching enable register masks the flags onto a single host interrupt line. One flag records that an inner transaction has finished. The other records a rising edge on the inner block's interrupt input.

Top module: `irb_bridge`

## Requirements
- R1: After reset, the control, lower data, upper data, interrupt enable and interrupt flag registers all read as zero, and `irq` is low.
- R2: Offset 0x00 always reads the parameter `ID_VALUE`, whose default is 0x1B0A0001.
- R3: At offset 0x04, the control word has these fields: bit 31 busy (read-only), bit 24 direction (1 = read from the inner space), bits 23:20 upper byte enables, bits 19:16 lower byte enables, and bits 7:0 the inner address. All other bits read as zero.
- R4: When the direction is 0, a host write to the lower data register at 0x08 stores the whole word and launches an inner write. When that write completes with bit 16 set, the inner byte at the stored address takes data bits 7:0.
- R5: A control write with bit 24 set launches an inner read. When the read completes with bit 16 set, the lower data register holds the fetched byte in bits 7:0, with bits 31:8 zero.
- R6: After each launch, busy reads 1 for exactly `LATENCY` cycles (default 4), starting in the cycle after the launching write.
- R7: Writes to the control register or the lower data register that arrive while busy is 1 are ignored. They change no field and launch nothing.
- R8: An access with bit 16 clear still runs for `LATENCY` cycles. A write leaves the inner byte unchanged, and a read leaves the lower data register unchanged.
- R9: Flag bit 0 (offset 0x14) is set when an inner transaction completes. Flag bit 1 is set on a rising edge of `sub_irq`. A level that stays high does not set the flag again after it has been cleared.
- R10: Writing 1 to a flag bit clears it. Writing 0 leaves the bit as it is.
- R11: The enable register at 0x10 holds bits 1:0. `irq` is the OR over both bits of (flag AND enable).
- R12: The upper data register at 0x0C is plain 32-bit storage that reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 5 | Host write byte offset |
| wr_data | input | 32 | Host write data |
| rd_addr | input | 5 | Host read byte offset |
| rd_data | output | 32 | Host read data, combinational from `rd_addr` |
| sub_irq | input | 1 | Interrupt level from the inner block |
| irq | output | 1 | Masked host interrupt |

## Verification
A register write takes effect at the clock edge that samples it, and `rd_data` follows `rd_addr` combinationally. The bench therefore reads each result half a cycle after the write's edge. Busy is sampled at every falling edge after a launch, and the number of high samples must equal `LATENCY`. Fetched bytes and flag bit 0 are checked only after that count ends. A rising edge on `sub_irq` is driven at a falling edge and is expected in the flag register one falling edge later, with `irq` following in the same sample.

// File: rtl/irb_pkg.sv
package irb_pkg;
  localparam int HOST_AW  = 5;
  localparam int DATA_W   = 32;
  localparam int INNER_AW = 8;
  localparam int INNER_DW = 8;
  localparam int NUM_IRQ  = 2;

  localparam logic [HOST_AW-1:0] OFF_ID    = 5'h00;
  localparam logic [HOST_AW-1:0] OFF_CTRL  = 5'h04;
  localparam logic [HOST_AW-1:0] OFF_LDATA = 5'h08;
  localparam logic [HOST_AW-1:0] OFF_UDATA = 5'h0C;
  localparam logic [HOST_AW-1:0] OFF_IEN   = 5'h10;
  localparam logic [HOST_AW-1:0] OFF_IFLG  = 5'h14;

  localparam int BIT_BUSY = 31;
  localparam int BIT_DIR  = 24;
  localparam int BEH_LSB  = 20;
  localparam int BEL_LSB  = 16;

  localparam int IRQ_IF  = 0;
  localparam int IRQ_SUB = 1;

  typedef struct packed {
    logic                dir;
    logic [3:0]          be_hi;
    logic [3:0]          be_lo;
    logic [INNER_AW-1:0] addr;
  } ctrl_t;
endpackage

// File: rtl/irb_seq.sv
module irb_seq #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(LAT + 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign done = busy_q && (cnt_q == CW'(1));
  assign busy = busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (launch) begin
      busy_d = 1'b1;
      cnt_d  = CW'(LAT);
    end else if (busy_q) begin
      if (cnt_q == CW'(1)) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/irb_inner_mem.sv
module irb_inner_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/irb_irq.sv
module irb_irq import irb_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_we,
  input  logic               clr_we,
  input  logic [NUM_IRQ-1:0] wbits,
  input  logic               done,
  input  logic               sub_irq,
  output logic [NUM_IRQ-1:0] en_q,
  output logic [NUM_IRQ-1:0] flag_q,
  output logic               irq
);
  logic [NUM_IRQ-1:0] en_d, flag_d, set_v, clr_v;
  logic               sub_q;

  always_comb begin
    set_v          = '0;
    set_v[IRQ_IF]  = done;
    set_v[IRQ_SUB] = sub_irq && !sub_q;
  end

  assign clr_v = clr_we ? wbits : '0;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_IRQ; gi++) begin : g_flag
      always_comb begin
        en_d[gi]   = en_we ? wbits[gi] : en_q[gi];
        flag_d[gi] = set_v[gi] | (flag_q[gi] & ~clr_v[gi]);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      flag_q <= '0;
      sub_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      flag_q <= flag_d;
      sub_q  <= sub_irq;
    end
  end

  assign irq = |(flag_q & en_q);
endmodule

// File: rtl/irb_bridge.sv
module irb_bridge import irb_pkg::*; #(
  parameter int          LATENCY  = 4,
  parameter logic [31:0] ID_VALUE = 32'h1B0A_0001
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [HOST_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [HOST_AW-1:0] rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               sub_irq,
  output logic               irq
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic               busy, done, launch;
  logic               wr_ctrl, wr_ldata, wr_udata, wr_ien, wr_iflg;
  logic               acc_ctrl, acc_ldata, store, fetch;
  ctrl_t              ctrl_q, ctrl_d;
  logic [DATA_W-1:0]  ldata_q, ldata_d, udata_q, udata_d;
  logic [INNER_DW-1:0] mem_rdata;
  logic [NUM_IRQ-1:0] en_q, flag_q;

  assign wr_ctrl  = wr_en && (wr_addr == OFF_CTRL);
  assign wr_ldata = wr_en && (wr_addr == OFF_LDATA);
  assign wr_udata = wr_en && (wr_addr == OFF_UDATA);
  assign wr_ien   = wr_en && (wr_addr == OFF_IEN);
  assign wr_iflg  = wr_en && (wr_addr == OFF_IFLG);

  assign acc_ctrl  = wr_ctrl && !busy;
  assign acc_ldata = wr_ldata && !busy;
  assign launch    = (acc_ctrl && wr_data[BIT_DIR]) || (acc_ldata && !ctrl_q.dir);
  assign store     = done && !ctrl_q.dir && ctrl_q.be_lo[0];
  assign fetch     = done && ctrl_q.dir && ctrl_q.be_lo[0];

  always_comb begin
    ctrl_d = ctrl_q;
    if (acc_ctrl) begin
      ctrl_d.dir   = wr_data[BIT_DIR];
      ctrl_d.be_hi = wr_data[BEH_LSB +: 4];
      ctrl_d.be_lo = wr_data[BEL_LSB +: 4];
      ctrl_d.addr  = wr_data[INNER_AW-1:0];
    end
  end

  always_comb begin
    ldata_d = ldata_q;
    if (acc_ldata)  ldata_d = wr_data;
    else if (fetch) ldata_d = {{(DATA_W-INNER_DW){1'b0}}, mem_rdata};
  end

  assign udata_d = wr_udata ? wr_data : udata_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q  <= '0;
      ldata_q <= '0;
      udata_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      ldata_q <= ldata_d;
      udata_q <= udata_d;
    end
  end

  irb_seq #(.LAT(LATENCY)) u_seq (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .launch (launch),
    .busy   (busy),
    .done   (done)
  );

  irb_inner_mem #(.AW(INNER_AW), .DW(INNER_DW)) u_mem (
    .clk   (clk),
    .we    (store),
    .addr  (ctrl_q.addr),
    .wdata (ldata_q[INNER_DW-1:0]),
    .rdata (mem_rdata)
  );

  irb_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en_we   (wr_ien),
    .clr_we  (wr_iflg),
    .wbits   (wr_data[NUM_IRQ-1:0]),
    .done    (done),
    .sub_irq (sub_irq),
    .en_q    (en_q),
    .flag_q  (flag_q),
    .irq     (irq)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      OFF_ID:    rd_data = ID_VALUE;
      OFF_CTRL: begin
        rd_data[BIT_BUSY]         = busy;
        rd_data[BIT_DIR]          = ctrl_q.dir;
        rd_data[BEH_LSB +: 4]     = ctrl_q.be_hi;
        rd_data[BEL_LSB +: 4]     = ctrl_q.be_lo;
        rd_data[INNER_AW-1:0]     = ctrl_q.addr;
      end
      OFF_LDATA: rd_data = ldata_q;
      OFF_UDATA: rd_data = udata_q;
      OFF_IEN:   rd_data[NUM_IRQ-1:0] = en_q;
      OFF_IFLG:  rd_data[NUM_IRQ-1:0] = flag_q;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irb_bridge_chk.sv
module irb_bridge_chk import irb_pkg::*; #(
  parameter int LAT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sub_irq,
  input logic               irq,
  input logic               busy,
  input ctrl_t              ctrl,
  input logic [NUM_IRQ-1:0] flag,
  input logic [NUM_IRQ-1:0] en
);
  logic [15:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 16'd1;
    else           run_q <= '0;
  end

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < 16'(LAT))); // R6
  AST_BUSY_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == 16'(LAT))); // R6
  AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ctrl)); // R7
  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> flag[IRQ_IF]); // R9
  AST_SUB_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_irq && !$past(sub_irq)) |=> flag[IRQ_SUB]); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq); // R11
endmodule

bind irb_bridge irb_bridge_chk #(.LAT(LATENCY)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .sub_irq (sub_irq),
  .irq     (irq),
  .busy    (busy),
  .ctrl    (ctrl_q),
  .flag    (flag_q),
  .en      (en_q)
);

// File: tb/irb_bridge_test.sv
module irb_bridge_test;
  localparam int          LAT = 4;
  localparam logic [31:0] IDV = 32'h1B0A_0001;
  localparam logic [4:0]  A_ID = 5'h00, A_CTRL = 5'h04, A_LD = 5'h08,
                          A_UD = 5'h0C, A_IEN = 5'h10, A_IFL = 5'h14;

  logic        clk, rst_n, wr_en, sub_irq, irq;
  logic [4:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0]  shadow [256];
  logic [31:0] ld_model;

  irb_bridge #(.LATENCY(LAT), .ID_VALUE(IDV)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sub_irq(sub_irq), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] mk_ctrl(logic dir, logic [3:0] bh, logic [3:0] bl, logic [7:0] a);
    return {7'd0, dir, bh, bl, 8'd0, a};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    rd(A_CTRL, v);
    while (v[31] && n < 1000) begin
      n++;
      @(negedge clk);
      rd(A_CTRL, v);
    end
  endtask

  task automatic done_flag();
    logic [31:0] v;
    rd(A_IFL, v);
    check("R9 done flag", {31'd0, v[0]}, 32'd1);
    wr(A_IFL, 32'h1);
    rd(A_IFL, v);
    check("R10 done flag cleared", {31'd0, v[0]}, 32'd0);
  endtask

  task automatic inner_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] bl);
    int n;
    wr(A_CTRL, mk_ctrl(1'b0, 4'h0, bl, a));
    wr(A_LD, d);
    wait_idle(n);
    check("R6 write busy length", n, LAT);
    ld_model = d;
    if (bl[0]) shadow[a] = d[7:0];
    done_flag();
  endtask

  task automatic inner_read(input logic [7:0] a, input logic [3:0] bl, input string req);
    int n;
    logic [31:0] v;
    wr(A_CTRL, mk_ctrl(1'b1, 4'h0, bl, a));
    wait_idle(n);
    check("R6 read busy length", n, LAT);
    if (bl[0]) ld_model = {24'd0, shadow[a]};
    rd(A_LD, v);
    check(req, v, ld_model);
    done_flag();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; sub_irq = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R2 identification
    rd(A_CTRL, v); check("R1 ctrl reset", v, 32'h0);
    rd(A_LD, v);   check("R1 ldata reset", v, 32'h0);
    rd(A_UD, v);   check("R1 udata reset", v, 32'h0);
    rd(A_IEN, v);  check("R1 enable reset", v, 32'h0);
    rd(A_IFL, v);  check("R1 flag reset", v, 32'h0);
    check("R1 irq reset", {31'd0, irq}, 32'd0);
    rd(A_ID, v);   check("R2 id value", v, IDV);

    // R3 field placement, unused bits read zero, direction 0 launches nothing
    wr(A_CTRL, 32'h7EA1_FF5C);
    rd(A_CTRL, v); check("R3 ctrl fields", v, mk_ctrl(1'b0, 4'hA, 4'h1, 8'h5C));

    // R12 upper data storage
    wr(A_UD, 32'hDEAD_BEEF);
    rd(A_UD, v); check("R12 udata", v, 32'hDEAD_BEEF);

    // R4 fill whole inner space
    for (int i = 0; i < 256; i++) inner_write(8'(i), $urandom, 4'h1);
    inner_read(8'h00, 4'h1, "R5 read first");
    inner_read(8'hFF, 4'h1, "R5 read last");

    // R7 writes during busy are ignored
    begin
      int n;
      logic [7:0] keep44;
      keep44 = shadow[8'h44];
      wr(A_CTRL, mk_ctrl(1'b0, 4'h0, 4'h1, 8'h33));
      wr(A_LD, 32'h0000_00A5);
      wr(A_CTRL, mk_ctrl(1'b1, 4'hF, 4'h1, 8'h44));
      wr(A_LD, 32'h5A5A_5A5A);
      wait_idle(n);
      rd(A_CTRL, v); check("R7 ctrl held", v, mk_ctrl(1'b0, 4'h0, 4'h1, 8'h33));
      rd(A_LD, v);   check("R7 ldata held", v, 32'h0000_00A5);
      shadow[8'h33] = 8'hA5;
      ld_model = 32'h0000_00A5;
      done_flag();
      inner_read(8'h33, 4'h1, "R7 target byte written");
      inner_read(8'h44, 4'h1, "R7 other byte untouched");
      check("R7 shadow kept", {24'd0, shadow[8'h44]}, {24'd0, keep44});
    end

    // R8 directed: no enable on write and on read
    inner_write(8'h10, 32'h0000_0077, 4'hE);
    inner_read(8'h10, 4'h1, "R8 write without enable");
    inner_read(8'h20, 4'h0, "R8 read without enable keeps ldata");

    // random mix
    for (int k = 0; k < 80; k++) begin
      logic [7:0] a;
      logic [3:0] bl;
      a  = 8'($urandom);
      bl = {3'($urandom), (($urandom % 4) != 0)};
      if ($urandom % 2) inner_write(a, $urandom, bl);
      else              inner_read(a, bl, "R5 R8 random read");
    end

    // R9 R10 R11 interrupts
    wr(A_IEN, 32'h2);
    rd(A_IEN, v); check("R11 enable readback", v, 32'h2);
    sub_irq = 1'b1;
    @(negedge clk);
    rd(A_IFL, v); check("R9 sub flag set", v, 32'h2);
    check("R11 irq on sub", {31'd0, irq}, 32'd1);
    wr(A_IFL, 32'h0);
    rd(A_IFL, v); check("R10 write zero keeps", v, 32'h2);
    wr(A_IFL, 32'h2);
    repeat (3) @(negedge clk);
    rd(A_IFL, v); check("R9 level does not reset flag", v, 32'h0);
    check("R11 irq low after clear", {31'd0, irq}, 32'd0);
    sub_irq = 1'b0;
    @(negedge clk);
    sub_irq = 1'b1;
    @(negedge clk);
    sub_irq = 1'b0;
    rd(A_IFL, v); check("R9 second rise", v, 32'h2);
    wr(A_IEN, 32'h0);
    check("R11 masked", {31'd0, irq}, 32'd0);
    begin
      int n;
      wr(A_CTRL, mk_ctrl(1'b1, 4'h0, 4'h1, 8'h01));
      wait_idle(n);
    end
    rd(A_IFL, v); check("R9 both flags", v, 32'h3);
    wr(A_IEN, 32'h1);
    check("R11 irq on done flag", {31'd0, irq}, 32'd1);
    wr(A_IFL, 32'h1);
    rd(A_IFL, v); check("R10 clear only bit0", v, 32'h2);
    check("R11 irq after bit0 clear", {31'd0, irq}, 32'd0);
    wr(A_IFL, 32'h3);
    rd(A_IFL, v); check("R10 clear all", v, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule